// File: doc/BRIEF.md
# Frame Pulse Format Detector and Bit Timer

This block sits at the front of a time-slot switch's serial ports. It watches a 4.096 MHz serial clock and an 8 kHz frame pulse, both taken in as plain inputs and oversampled by a faster system clock. From the pulse alone it decides which backplane convention is in use: an active-low pulse (ST-BUS style) or an active-high pulse (GCI style). It then tracks whether the pulse keeps arriving at the exact frame period.

Once a valid pulse has been seen, a bit timer runs on the serial clock edges. Which edge marks a cell boundary and which edge samples data depends on the detected format. The timer gives single-cycle boundary, sample and frame-start strobes, plus channel and bit counts, to the serial-to-parallel and parallel-to-serial logic around it. Each valid pulse realigns the timer. Between pulses the timer keeps counting on its own.

Top module: `tsw_frame_timer`

## Requirements
- R1: After reset every output is 0, and no strobe is produced until the first qualified frame pulse has been seen.
- R2: A frame pulse qualifies when it follows an earlier pulse-level transition and contains 1 or 2 rising serial clock edges. A qualified high pulse sets `fmt_gci_o` to 1 (active-high format). A qualified low pulse sets it to 0 (active-low format).
- R3: A pulse-level run containing more than 2 rising serial clock edges is ignored. It leaves the format unchanged and does not realign the timer.
- R4: `locked_o` becomes 1 when a qualified pulse arrives exactly 512 rising serial clock edges after the previous qualified pulse, with the same polarity.
- R5: A qualified pulse at any other spacing, or of the other polarity, clears `locked_o`.
- R6: `locked_o` is cleared when 513 rising serial clock edges pass without a qualified pulse.
- R7: The first boundary-type serial clock edge after a qualified pulse raises `frame_start_o` and `bit_boundary_o` together. At that point `chan_o` = 0 and `bit_o` = 0.
- R8: Boundary-type edges are falling edges in the active-low format and rising edges in the active-high format. Every second one of them is a cell boundary and pulses `bit_boundary_o`.
- R9: `sample_o` pulses on the opposite-type edge that follows the mid-cell edge, three quarters into the cell.
- R10: At each cell boundary `bit_o` advances 0..7. On wrapping to 0, `chan_o` advances 0..31. Wrapping to channel 0, bit 0 raises `frame_start_o`, so the timer free-runs between pulses.
- R11: The strobes are one system cycle wide, and `bit_boundary_o` never coincides with `sample_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | 4.096 MHz serial clock, asynchronous |
| fpulse_i | input | 1 | Frame pulse, either polarity, asynchronous |
| fmt_gci_o | output | 1 | 1 = active-high format, 0 = active-low format |
| locked_o | output | 1 | Pulse seen at the exact frame period |
| frame_start_o | output | 1 | Strobe at the boundary of channel 0, bit 0 |
| bit_boundary_o | output | 1 | Strobe at each bit cell boundary |
| sample_o | output | 1 | Strobe at the three-quarter sampling point |
| chan_o | output | 5 | Current channel number |
| bit_o | output | 3 | Current bit number within the channel |

## Verification
The assertions assume that serial clock edges reach the block at least two system cycles apart. This holds for any system clock of at least four times the serial rate, and the stimulus uses eight. Frame pulse transitions are assumed never to land on the same system cycle as a serial clock edge. The stimulus keeps to this by moving the pulse only in the middle of a serial half-period. Random frames vary the pulse width across the qualifying limit, shift the frame length, and drop pulses. A reference model, fed the same edges, predicts every strobe, count and flag.

// File: rtl/tsw_fp_pkg.sv
// Package: shared types for the frame pulse format detector and bit timer.
// Assumes nothing; holds only the format encoding used across the block.
package tsw_fp_pkg;

    // Backplane format encoding; the value matches the top-level flag.
    typedef enum logic {
        FMT_STBUS = 1'b0,   // active-low frame pulse
        FMT_GCI   = 1'b1    // active-high frame pulse
    } fp_fmt_e;

endpackage

// File: rtl/tsw_fp_sync.sv
// Module: tsw_fp_sync
// Brings WIDTH asynchronous signals into the system clock domain through
// STAGES flops each and flags rising and falling transitions for one cycle.
// Assumes STAGES >= 2 and that each input holds for at least two cycles.
module tsw_fp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Shift the input through the synchroniser and remember the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign rise_o[g] =  chain_q[STAGES-1] & ~prev_q;
        assign fall_o[g] = ~chain_q[STAGES-1] &  prev_q;
    end

endmodule

// File: rtl/tsw_fp_detect.sv
// Module: tsw_fp_detect
// Measures each frame-pulse level run in rising serial clock edges and
// qualifies short runs as frame pulses, which fixes the backplane format.
// Tracks the spacing between qualified pulses to maintain a lock flag.
// Assumes pulse transitions never share a system cycle with a clock edge.
module tsw_fp_detect
    import tsw_fp_pkg::*;
#(
    parameter int MAX_PULSE_CLKS = 2,
    parameter int FRAME_CLKS     = 512
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sclk_rise,
    input  logic    fp_rise,
    input  logic    fp_fall,
    output logic    pulse_ok_o,
    output fp_fmt_e fmt_o,
    output logic    locked_o
);

    localparam int RUN_W = $clog2(MAX_PULSE_CLKS + 2);
    localparam int PER_W = $clog2(FRAME_CLKS + 2);
    localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(MAX_PULSE_CLKS);
    localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(MAX_PULSE_CLKS + 1);
    localparam logic [PER_W-1:0] PER_FRAME = PER_W'(FRAME_CLKS);
    localparam logic [PER_W-1:0] PER_SAT   = PER_W'(FRAME_CLKS + 1);

    logic [RUN_W-1:0] run_q;
    logic [PER_W-1:0] per_q;
    logic             seen_q;
    logic             fp_edge;
    fp_fmt_e          pulse_fmt;
    fp_fmt_e          fmt_q;
    logic             locked_q;

    assign fp_edge    = fp_rise | fp_fall;
    assign pulse_fmt  = fp_fall ? FMT_GCI : FMT_STBUS;
    assign pulse_ok_o = fp_edge && seen_q && (run_q != '0) && (run_q <= RUN_MAX);

    // Count rising clock edges within the current pulse-level run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            seen_q <= 1'b0;
        end else if (fp_edge) begin
            run_q  <= '0;
            seen_q <= 1'b1;
        end else if (sclk_rise && run_q != RUN_SAT) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Count rising clock edges since the last qualified pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= PER_SAT;
        end else if (pulse_ok_o) begin
            per_q <= '0;
        end else if (sclk_rise && per_q != PER_SAT) begin
            per_q <= per_q + 1'b1;
        end
    end

    // Hold the format and judge each qualified pulse against the frame period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q    <= FMT_STBUS;
            locked_q <= 1'b0;
        end else if (pulse_ok_o) begin
            fmt_q    <= pulse_fmt;
            locked_q <= (per_q == PER_FRAME) && (pulse_fmt == fmt_q);
        end else if (sclk_rise && per_q == PER_FRAME) begin
            locked_q <= 1'b0;
        end
    end

    assign fmt_o    = fmt_q;
    assign locked_o = locked_q;

endmodule

// File: rtl/tsw_fp_timer.sv
// Module: tsw_fp_timer
// Bit cell timer: picks the boundary and sampling clock edges from the
// format, emits boundary, sample and frame-start strobes, and keeps the
// bit and channel counts. A qualified pulse forces the next boundary to
// channel 0, bit 0; otherwise the timer free-runs.
// Assumes a qualified pulse never shares a cycle with a clock edge.
module tsw_fp_timer
    import tsw_fp_pkg::*;
#(
    parameter int BITS_PER_CHAN = 8,
    parameter int CHANNELS      = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sclk_rise,
    input  logic                        sclk_fall,
    input  fp_fmt_e                     fmt,
    input  logic                        pulse_ok,
    output logic                        frame_start_o,
    output logic                        bit_boundary_o,
    output logic                        sample_o,
    output logic [$clog2(CHANNELS)-1:0] chan_o,
    output logic [$clog2(BITS_PER_CHAN)-1:0] bit_o
);

    localparam int BIT_W  = $clog2(BITS_PER_CHAN);
    localparam int CHAN_W = $clog2(CHANNELS);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_CHAN - 1);
    localparam logic [CHAN_W-1:0] LAST_CHAN = CHAN_W'(CHANNELS - 1);

    logic              armed_q;
    logic              pending_q;
    logic              late_q;
    logic              bnd_edge;
    logic              opp_edge;
    logic [BIT_W-1:0]  bit_q;
    logic [CHAN_W-1:0] chan_q;
    logic              fs_q;
    logic              bb_q;
    logic              smp_q;

    assign bnd_edge = (fmt == FMT_GCI) ? sclk_rise : sclk_fall;
    assign opp_edge = (fmt == FMT_GCI) ? sclk_fall : sclk_rise;

    // Advance the half-cell phase, the counters and the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            pending_q <= 1'b0;
            late_q    <= 1'b0;
            bit_q     <= '0;
            chan_q    <= '0;
            fs_q      <= 1'b0;
            bb_q      <= 1'b0;
            smp_q     <= 1'b0;
        end else begin
            fs_q  <= 1'b0;
            bb_q  <= 1'b0;
            smp_q <= 1'b0;
            if (pulse_ok) begin
                armed_q   <= 1'b1;
                pending_q <= 1'b1;
            end else if (armed_q) begin
                if (bnd_edge) begin
                    if (pending_q || late_q) begin
                        bb_q      <= 1'b1;
                        pending_q <= 1'b0;
                        late_q    <= 1'b0;
                        if (pending_q) begin
                            bit_q  <= '0;
                            chan_q <= '0;
                            fs_q   <= 1'b1;
                        end else if (bit_q == LAST_BIT) begin
                            bit_q <= '0;
                            if (chan_q == LAST_CHAN) begin
                                chan_q <= '0;
                                fs_q   <= 1'b1;
                            end else begin
                                chan_q <= chan_q + 1'b1;
                            end
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end else begin
                        late_q <= 1'b1;
                    end
                end
                if (opp_edge && late_q && !pending_q) begin
                    smp_q <= 1'b1;
                end
            end
        end
    end

    assign frame_start_o  = fs_q;
    assign bit_boundary_o = bb_q;
    assign sample_o       = smp_q;
    assign chan_o         = chan_q;
    assign bit_o          = bit_q;

endmodule

// File: rtl/tsw_frame_timer.sv
// Module: tsw_frame_timer (top)
// Frame pulse format detector and bit timer for a serial backplane.
// Synchronises the serial clock and frame pulse, detects the format and
// lock, and drives the bit cell timer.
// Assumes the system clock runs at least 4x the serial clock.
module tsw_frame_timer
    import tsw_fp_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int MAX_PULSE_CLKS = 2,
    parameter int BITS_PER_CHAN  = 8,
    parameter int CHANNELS       = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sclk_i,
    input  logic                             fpulse_i,
    output logic                             fmt_gci_o,
    output logic                             locked_o,
    output logic                             frame_start_o,
    output logic                             bit_boundary_o,
    output logic                             sample_o,
    output logic [$clog2(CHANNELS)-1:0]      chan_o,
    output logic [$clog2(BITS_PER_CHAN)-1:0] bit_o
);

    // Two serial clocks per bit cell.
    localparam int FRAME_CLKS = 2 * BITS_PER_CHAN * CHANNELS;
    localparam int IDX_SCLK   = 0;
    localparam int IDX_FP     = 1;

    logic [1:0] rise;
    logic [1:0] fall;
    logic       pulse_ok;
    fp_fmt_e    fmt;

    tsw_fp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({fpulse_i, sclk_i}),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    tsw_fp_detect #(.MAX_PULSE_CLKS(MAX_PULSE_CLKS), .FRAME_CLKS(FRAME_CLKS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (rise[IDX_SCLK]),
        .fp_rise    (rise[IDX_FP]),
        .fp_fall    (fall[IDX_FP]),
        .pulse_ok_o (pulse_ok),
        .fmt_o      (fmt),
        .locked_o   (locked_o)
    );

    tsw_fp_timer #(.BITS_PER_CHAN(BITS_PER_CHAN), .CHANNELS(CHANNELS)) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk_rise      (rise[IDX_SCLK]),
        .sclk_fall      (fall[IDX_SCLK]),
        .fmt            (fmt),
        .pulse_ok       (pulse_ok),
        .frame_start_o  (frame_start_o),
        .bit_boundary_o (bit_boundary_o),
        .sample_o       (sample_o),
        .chan_o         (chan_o),
        .bit_o          (bit_o)
    );

    assign fmt_gci_o = (fmt == FMT_GCI);

endmodule

// File: rtl/tsw_frame_timer_chk.sv
// Module: tsw_frame_timer_chk
// Property checker for tsw_frame_timer, attached by bind below.
// Assumes serial clock edges arrive at least two system cycles apart.
module tsw_frame_timer_chk #(
    parameter int BITS_PER_CHAN = 8,
    parameter int CHANNELS      = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             fmt_gci_o,
    input logic                             locked_o,
    input logic                             frame_start_o,
    input logic                             bit_boundary_o,
    input logic                             sample_o,
    input logic [$clog2(CHANNELS)-1:0]      chan_o,
    input logic [$clog2(BITS_PER_CHAN)-1:0] bit_o
);

    localparam int BIT_W = $clog2(BITS_PER_CHAN);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_CHAN - 1);

    AST_BB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) bit_boundary_o |=> !bit_boundary_o); // R11
    AST_NO_BB_SAMPLE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(bit_boundary_o && sample_o)); // R11
    AST_FRAME_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) frame_start_o |-> (bit_boundary_o && chan_o == '0 && bit_o == '0)); // R7
    AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) (bit_boundary_o && !frame_start_o) |-> ((bit_o == $past(bit_o) + 1'b1) || (bit_o == '0 && $past(bit_o) == LAST_BIT))); // R10
    AST_CHAN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) (bit_boundary_o && !frame_start_o && bit_o == '0) |-> (chan_o == $past(chan_o) + 1'b1)); // R10
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bit_boundary_o |-> ($stable(bit_o) && $stable(chan_o))); // R10
    AST_FMT_CHANGE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (fmt_gci_o != $past(fmt_gci_o)) |-> !locked_o); // R5

endmodule

bind tsw_frame_timer tsw_frame_timer_chk #(
    .BITS_PER_CHAN (BITS_PER_CHAN),
    .CHANNELS      (CHANNELS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fmt_gci_o      (fmt_gci_o),
    .locked_o       (locked_o),
    .frame_start_o  (frame_start_o),
    .bit_boundary_o (bit_boundary_o),
    .sample_o       (sample_o),
    .chan_o         (chan_o),
    .bit_o          (bit_o)
);

// File: tb/tsw_frame_timer_bench.sv
// Bench for tsw_frame_timer: the serial clock runs at 1/8 of the system clock.
// Each serial half-period, a reference model predicts strobes, counts and flags.
module tsw_frame_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SYS   = 4;        // system cycles per serial half-period
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       fpulse = 1'b1;
    logic       fmt_gci_o, locked_o, frame_start_o, bit_boundary_o, sample_o;
    logic [4:0] chan_o;
    logic [2:0] bit_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // reference model state
    bit m_seen = 0, m_gci = 0, m_lock = 0, m_armed = 0, m_pend = 0, m_late = 0;
    bit m_level = 1;
    int m_run = 0, m_per = 513, m_bit = 0, m_chan = 0;
    bit prev_bb = 0;

    tsw_frame_timer u_tsw_frame_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk_i         (sclk),
        .fpulse_i       (fpulse),
        .fmt_gci_o      (fmt_gci_o),
        .locked_o       (locked_o),
        .frame_start_o  (frame_start_o),
        .bit_boundary_o (bit_boundary_o),
        .sample_o       (sample_o),
        .chan_o         (chan_o),
        .bit_o          (bit_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model reaction to one serial clock edge.
    task automatic model_edge(input bit rise, output bit e_bb, output bit e_fs, output bit e_sm);
        bit bnd;
        e_bb = 0; e_fs = 0; e_sm = 0;
        if (rise) begin
            if (m_run < 3) m_run++;
            if (m_per == 512) m_lock = 0;
            if (m_per < 513) m_per++;
        end
        if (m_armed) begin
            bnd = m_gci ? rise : !rise;
            if (bnd) begin
                if (m_pend || m_late) begin
                    e_bb = 1;
                    if (m_pend) begin
                        m_bit = 0; m_chan = 0; e_fs = 1;
                    end else begin
                        m_bit++;
                        if (m_bit == 8) begin
                            m_bit = 0; m_chan++;
                            if (m_chan == 32) begin m_chan = 0; e_fs = 1; end
                        end
                    end
                    m_pend = 0; m_late = 0;
                end else begin
                    m_late = 1;
                end
            end else if (m_late && !m_pend) begin
                e_sm = 1;
            end
        end
    endtask

    // Model reaction to a frame pulse level change.
    task automatic model_fp(input bit nv);
        bit q;
        q = m_seen && m_run >= 1 && m_run <= 2;
        if (q) begin
            m_lock  = (m_per == 512) && (m_level == m_gci);
            m_gci   = m_level;
            m_per   = 0;
            m_armed = 1;
            m_pend  = 1;
        end
        m_seen = 1; m_run = 0; m_level = nv;
    endtask

    // One serial half-period: toggle sclk now, optionally move the pulse mid-way.
    task automatic do_half(input bit new_fp);
        bit e_bb, e_fs, e_sm, s_lock, s_gci, viol;
        int c_bb, c_fs, c_sm;
        s_lock = m_lock; s_gci = m_gci;
        c_bb = 0; c_fs = 0; c_sm = 0; viol = 0;
        sclk = ~sclk;
        model_edge(sclk, e_bb, e_fs, e_sm);
        for (int k = 1; k <= HALF_SYS; k++) begin
            @(negedge clk);
            c_bb += int'(bit_boundary_o);
            c_fs += int'(frame_start_o);
            c_sm += int'(sample_o);
            if ((bit_boundary_o && prev_bb) || (bit_boundary_o && sample_o)) viol = 1;
            prev_bb = bit_boundary_o;
            if (k == 1) begin
                check(locked_o == s_lock, "R4/R5/R6", "locked", int'(locked_o), int'(s_lock));
                check(fmt_gci_o == s_gci, "R2", "format", int'(fmt_gci_o), int'(s_gci));
            end
            if (k == 2 && new_fp != fpulse) begin
                fpulse = new_fp;
                model_fp(new_fp);
            end
        end
        check(c_bb == int'(e_bb), "R8", "bit boundary count", c_bb, int'(e_bb));
        check(c_fs == int'(e_fs), "R7", "frame start count", c_fs, int'(e_fs));
        check(c_sm == int'(e_sm), "R9", "sample count", c_sm, int'(e_sm));
        check(int'(bit_o) == m_bit, "R10", "bit count", int'(bit_o), m_bit);
        check(int'(chan_o) == m_chan, "R10", "channel count", int'(chan_o), m_chan);
        check(!viol, "R11", "strobe width/overlap", int'(viol), 0);
    endtask

    task automatic idle(input int n, input bit lvl);
        for (int h = 0; h < n; h++) do_half(lvl);
    endtask

    // A frame of len half-periods; pulse of width halves at its start (0 = none).
    task automatic frame(input int len, input int width, input bit act);
        for (int h = 0; h < len; h++) do_half((h < width) ? act : !act);
    endtask

    initial begin
        int seed_v, pick;
        seed_v = $urandom(32'h1F2E3D4C);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!fmt_gci_o && !locked_o && !frame_start_o && !bit_boundary_o && !sample_o,
              "R1", "flags after reset", int'({fmt_gci_o, locked_o, frame_start_o, bit_boundary_o, sample_o}), 0);
        check(chan_o == '0 && bit_o == '0, "R1", "counts after reset", int'({chan_o, bit_o}), 0);
        idle(20, 1'b1);   // R1: no strobes before the first pulse (model expects none)

        // active-low format, steady frames
        repeat (3) frame(1024, 2, 1'b0);
        check(locked_o == 1'b1, "R4", "lock after steady low pulses", int'(locked_o), 1);
        check(fmt_gci_o == 1'b0, "R2", "low pulse format", int'(fmt_gci_o), 0);
        // over-long pulse ignored
        frame(1024, 6, 1'b0);
        check(fmt_gci_o == 1'b0, "R3", "format after wide pulse", int'(fmt_gci_o), 0);
        repeat (2) frame(1024, 2, 1'b0);
        // misplaced pulse
        frame(700, 2, 1'b0);
        frame(1024, 2, 1'b0);
        check(locked_o == 1'b0, "R5", "lock after early pulse", int'(locked_o), 0);
        frame(1024, 2, 1'b0);
        // missing pulse
        frame(2048, 0, 1'b0);
        check(locked_o == 1'b0, "R6", "lock after missing pulse", int'(locked_o), 0);

        // switch to active-high format
        idle(20, 1'b0);
        repeat (3) frame(1024, 2, 1'b1);
        check(fmt_gci_o == 1'b1, "R2", "high pulse format", int'(fmt_gci_o), 1);
        check(locked_o == 1'b1, "R4", "lock after steady high pulses", int'(locked_o), 1);

        // constrained random frames
        for (int f = 0; f < 8; f++) begin
            pick = int'($urandom_range(0, 7));
            if (pick == 0)      frame(1024, 6 + 2 * int'($urandom_range(0, 1)), 1'b1);
            else if (pick == 1) frame(1000 + int'($urandom_range(0, 48)), 2, 1'b1);
            else if (pick == 2) frame(1024, 4, 1'b1);
            else                frame(1024, 2, 1'b1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule